// File: doc/BRIEF.md
# Pipelined Reduction Tree

This block folds a fixed number of equal-width operands into one value with a single associative operator. The operator is chosen at build time: wrapping sum, truncating product, or a bitwise AND, OR or XOR. Operands are combined in pairs, one tree level after another. The number of levels is the ceiling of log2 of the operand count. When a level has an odd number of values, the unpaired one is forwarded unchanged to the next level.

A build-time switch sets the timing. In combinational mode the tree has no registers, so the result and its valid flag follow the inputs in the same cycle. In registered mode, pipeline registers are placed after every K levels. K depends on the operator and the operand width. The level that produces the result is always registered, so the output comes straight from a flop. The output valid is the input valid delayed by the number of register stages.

Top module: `rtree_top`

## Requirements
- R1: Every result equals the left-to-right fold of all N operands with the selected operator. Operand i occupies bits [i*W +: W] of the input vector. The operator codes are 0 for add, 1 for multiply, 2 for AND, 3 for OR and 4 for XOR.
- R2: Addition wraps modulo 2^W.
- R3: Multiplication keeps only the low W bits of each product.
- R4: When N is not a power of two, the unpaired operand at a level is carried forward unchanged, and the result is still the full fold.
- R5: In combinational mode the latency is zero: out_valid and out_result follow the inputs within the same cycle.
- R6: In registered mode with add, a stage closes every 5 levels, and the last level is always registered. The latency is ceil(D/5), where D is the depth.
- R7: In registered mode with multiply, a stage closes after every level when W > 16 and every 2 levels when W <= 16. The latency is ceil(D/1) or ceil(D/2) respectively.
- R8: In registered mode with AND, OR or XOR, a stage closes every 10 levels. The latency is ceil(D/10).
- R10: out_valid is in_valid delayed by the latency. Vectors presented on consecutive cycles come out on consecutive cycles, in order.
- R11: A synchronous active-high reset clears every in-flight valid flag. No result appears for a vector that was accepted before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vector is valid this cycle |
| in_ops | input | N_OPS*OP_W | Packed operands, operand i at bits [i*OP_W +: OP_W] |
| out_valid | output | 1 | Result is valid |
| out_result | output | OP_W | Folded result |

## Verification
A new operand vector can be accepted in the same cycle that an earlier vector's result leaves the last stage. The bench provokes this on the two-stage multiply build. It presents three vectors on back-to-back cycles and checks that each of the three results appears on its own consecutive cycle with the right value. Reset can also meet a vector that is still in flight. The bench pulses reset one cycle after accepting a vector on the three-stage build and requires that out_valid stays low through the slot where that result would have appeared.

// File: rtl/rtree_pkg.sv
package rtree_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MUL = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;

  // number of values present at tree level l (level 0 = inputs)
  function automatic int lvl_cnt(input int n, input int l);
    int c;
    c = n;
    for (int i = 0; i < l; i++) c = (c + 1) / 2;
    return c;
  endfunction

  // first node index of level l in the flat node array
  function automatic int lvl_base(input int n, input int l);
    int b;
    b = 0;
    for (int i = 0; i < l; i++) b += lvl_cnt(n, i);
    return b;
  endfunction

  function automatic int tree_depth(input int n);
    int c;
    int d;
    c = n;
    d = 0;
    while (c > 1) begin
      c = (c + 1) / 2;
      d++;
    end
    return d;
  endfunction

  function automatic int node_total(input int n);
    return lvl_base(n, tree_depth(n) + 1);
  endfunction

  // levels covered by one pipeline stage
  function automatic int stage_span(input op_e op, input int w);
    case (op)
      OP_ADD:  return 5;
      OP_MUL:  return (w > 16) ? 1 : 2;
      default: return 10;
    endcase
  endfunction

  // register after completing level l (1-based)?
  function automatic bit reg_after(input op_e op, input int w, input bit piped,
                                   input int n, input int l);
    return piped && (((l % stage_span(op, w)) == 0) || (l == tree_depth(n)));
  endfunction

  function automatic int pipe_latency(input op_e op, input int w, input bit piped,
                                      input int n);
    int s;
    s = 0;
    for (int l = 1; l <= tree_depth(n); l++)
      if (reg_after(op, w, piped, n, l)) s++;
    return s;
  endfunction

endpackage

// File: rtl/rtree_op2.sv
module rtree_op2 #(
  parameter int              W      = 16,
  parameter rtree_pkg::op_e  OP_SEL = rtree_pkg::OP_ADD
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import rtree_pkg::*;

  always_comb begin
    case (OP_SEL)
      OP_ADD:  y = a + b;
      OP_MUL:  y = a * b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rtree_dreg.sv
module rtree_dreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) q <= d;

endmodule

// File: rtl/rtree_top.sv
module rtree_top #(
  parameter int             N_OPS  = 8,
  parameter int             OP_W   = 16,
  parameter rtree_pkg::op_e OP_SEL = rtree_pkg::OP_ADD,
  parameter bit             PIPED  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [N_OPS*OP_W-1:0] in_ops,
  output logic                  out_valid,
  output logic [OP_W-1:0]       out_result
);
  import rtree_pkg::*;

  localparam int DEPTH = tree_depth(N_OPS);
  localparam int NODES = node_total(N_OPS);

  logic [OP_W-1:0] node [NODES];
  logic            vld  [DEPTH+1];

  for (genvar i = 0; i < N_OPS; i++) begin : g_in
    assign node[i] = in_ops[i*OP_W +: OP_W];
  end
  assign vld[0] = in_valid;

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int IC  = lvl_cnt(N_OPS, l);
    localparam int OC  = lvl_cnt(N_OPS, l + 1);
    localparam int IB  = lvl_base(N_OPS, l);
    localparam int OB  = lvl_base(N_OPS, l + 1);
    localparam bit REG = reg_after(OP_SEL, OP_W, PIPED, N_OPS, l + 1);

    for (genvar j = 0; j < OC; j++) begin : g_node
      logic [OP_W-1:0] y;
      if (2*j + 1 < IC) begin : g_pair
        rtree_op2 #(.W(OP_W), .OP_SEL(OP_SEL)) u_op (
          .a(node[IB + 2*j]), .b(node[IB + 2*j + 1]), .y(y));
      end else begin : g_carry
        assign y = node[IB + 2*j];
      end
      if (REG) begin : g_reg
        rtree_dreg #(.W(OP_W)) u_dreg (.clk(clk), .d(y), .q(node[OB + j]));
      end else begin : g_wire
        assign node[OB + j] = y;
      end
    end

    if (REG) begin : g_vreg
      always_ff @(posedge clk) begin
        if (rst) vld[l+1] <= 1'b0;
        else     vld[l+1] <= vld[l];
      end
    end else begin : g_vwire
      assign vld[l+1] = vld[l];
    end
  end

  assign out_valid  = vld[DEPTH];
  assign out_result = node[NODES-1];

endmodule

// File: rtl/rtree_chk.sv
module rtree_chk #(
  parameter int             N_OPS  = 8,
  parameter int             OP_W   = 16,
  parameter rtree_pkg::op_e OP_SEL = rtree_pkg::OP_ADD,
  parameter bit             PIPED  = 1'b1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [N_OPS*OP_W-1:0] in_ops,
  input logic                  out_valid,
  input logic [OP_W-1:0]       out_result
);
  import rtree_pkg::*;

  localparam int LAT = pipe_latency(OP_SEL, OP_W, PIPED, N_OPS);

  function automatic logic [OP_W-1:0] lin_fold(input logic [N_OPS*OP_W-1:0] v);
    logic [OP_W-1:0] acc;
    logic [OP_W-1:0] x;
    acc = v[OP_W-1:0];
    for (int i = 1; i < N_OPS; i++) begin
      x = v[i*OP_W +: OP_W];
      case (OP_SEL)
        OP_ADD:  acc = acc + x;
        OP_MUL:  acc = acc * x;
        OP_AND:  acc = acc & x;
        OP_OR:   acc = acc | x;
        default: acc = acc ^ x;
      endcase
    end
    return acc;
  endfunction

  logic                  t_vld;
  logic [N_OPS*OP_W-1:0] t_ops;

  if (LAT > 0) begin : g_shadow
    logic                  sv [LAT];
    logic [N_OPS*OP_W-1:0] sd [LAT];
    always_ff @(posedge clk) begin
      sv[0] <= rst ? 1'b0 : in_valid;
      sd[0] <= in_ops;
      for (int i = 1; i < LAT; i++) begin
        sv[i] <= rst ? 1'b0 : sv[i-1];
        sd[i] <= sd[i-1];
      end
    end
    assign t_vld = sv[LAT-1];
    assign t_ops = sd[LAT-1];

    // R11: a result in flight at reset never emerges
    p_reset_flush_r11: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !out_valid);
  end else begin : g_direct
    assign t_vld = in_valid;
    assign t_ops = in_ops;
  end

  // R10: valid emerges exactly LAT cycles after it enters
  p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
    t_vld |-> out_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !t_vld |-> !out_valid);
  // R1: result matches a linear fold of the matching input vector
  p_fold_match_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_result == lin_fold(t_ops));

endmodule

bind rtree_top rtree_chk #(
  .N_OPS(N_OPS), .OP_W(OP_W), .OP_SEL(OP_SEL), .PIPED(PIPED)
) u_rtree_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ops(in_ops),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/test_rtree_top.sv
`timescale 1ns/1ps
module test_rtree_top;
  localparam int NCFG = 8;
  // per build: operand count, width, operator code, registered, expected latency
  localparam int CN [NCFG] = '{8, 8, 8, 8, 5, 5, 64, 2048};
  localparam int CW [NCFG] = '{16, 16, 24, 16, 12, 12, 8, 2};
  localparam int CO [NCFG] = '{0, 1, 1, 4, 2, 3, 0, 3};
  localparam int CP [NCFG] = '{1, 1, 1, 1, 0, 0, 1, 1};
  localparam int CL [NCFG] = '{1, 2, 3, 1, 0, 0, 2, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4095:0] ops [NCFG];
  logic          vin [NCFG];
  logic          vout [NCFG];
  logic [31:0]   res [NCFG];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < NCFG; k++) begin : g_dut
    logic [CW[k]-1:0] r;
    logic             v;
    rtree_top #(
      .N_OPS(CN[k]), .OP_W(CW[k]),
      .OP_SEL(rtree_pkg::op_e'(CO[k])), .PIPED(CP[k] != 0)
    ) i_rtree_top (
      .clk(clk), .rst(rst), .in_valid(vin[k]),
      .in_ops(ops[k][CN[k]*CW[k]-1:0]),
      .out_valid(v), .out_result(r));
    assign vout[k] = v;
    assign res[k]  = 32'(r);
  end

  function automatic logic [31:0] ref_fold(input int k, input logic [4095:0] v);
    logic [63:0] m;
    logic [63:0] acc;
    logic [63:0] x;
    m = (64'd1 << CW[k]) - 64'd1;
    acc = v & m;
    for (int i = 1; i < CN[k]; i++) begin
      x = (v >> (i*CW[k])) & m;
      case (CO[k])
        0: acc = (acc + x) & m;
        1: acc = (acc * x) & m;
        2: acc = acc & x;
        3: acc = acc | x;
        default: acc = acc ^ x;
      endcase
    end
    return acc[31:0];
  endfunction

  function automatic logic [4095:0] rnd_vec();
    logic [4095:0] v;
    for (int i = 0; i < 128; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // one vector through build k, checked in the cycle its result is due
  task automatic apply_check(input int k, input logic [4095:0] v, input string tag);
    logic [31:0] exp;
    exp = ref_fold(k, v);
    @(negedge clk);
    ops[k] = v;
    vin[k] = 1'b1;
    if (CL[k] == 0) begin
      #1;
      chk(vout[k] == 1'b1, {tag, " valid"}, 32'(vout[k]), 32'd1);
      chk(res[k] == exp, tag, res[k], exp);
      @(negedge clk);
      vin[k] = 1'b0;
    end else begin
      @(negedge clk);
      vin[k] = 1'b0;
      repeat (CL[k] - 1) @(posedge clk);
      #1;
      chk(vout[k] == 1'b1, {tag, " valid"}, 32'(vout[k]), 32'd1);
      chk(res[k] == exp, tag, res[k], exp);
    end
  endtask

  // R11: reset state of every build
  task automatic t_reset_state();
    for (int k = 0; k < NCFG; k++)
      chk(vout[k] == 1'b0, "R11 reset state", 32'(vout[k]), 32'd0);
  endtask

  // R5 R6 R7 R8: measured latency against the interval rules
  task automatic t_latency(input int k, input string tag);
    int lat;
    lat = -1;
    @(negedge clk);
    ops[k] = rnd_vec();
    vin[k] = 1'b1;
    #1;
    if (vout[k]) lat = 0;
    @(negedge clk);
    if (vout[k] && lat < 0) lat = 1;
    vin[k] = 1'b0;
    for (int c = 2; c <= 8; c++) begin
      @(negedge clk);
      if (vout[k] && lat < 0) lat = c;
    end
    chk(lat == CL[k], tag, 32'(lat), 32'(CL[k]));
  endtask

  // R1 R4: random vectors on a build
  task automatic t_random(input int k, input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) apply_check(k, rnd_vec(), tag);
  endtask

  // R2: sums that overflow the width
  task automatic t_wrap();
    logic [4095:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = 16'hFFFF;
    apply_check(0, v, "R2 wrap 8x16");
    chk(res[0] == 32'h0000FFF8, "R2 wrap value", res[0], 32'h0000FFF8);
    v = '0;
    for (int i = 0; i < 64; i++) v[i*8 +: 8] = 8'hFF;
    apply_check(6, v, "R2 wrap 64x8");
    chk(res[6] == 32'h000000C0, "R2 wrap value 64", res[6], 32'h000000C0);
  endtask

  // R3: products beyond the width are truncated
  task automatic t_mul_trunc();
    logic [4095:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) v[i*24 +: 24] = 24'h001000;
    apply_check(2, v, "R3 mul trunc 24");
    chk(res[2] == 32'd0, "R3 mul trunc zero", res[2], 32'd0);
    v = '0;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = 16'd3;
    apply_check(1, v, "R3 mul 3^8");
    t_random(1, 6, "R3 mul random 16");
    t_random(2, 6, "R3 mul random 24");
  endtask

  // R4: odd counts, carried operand decides the AND result
  task automatic t_odd();
    logic [4095:0] v;
    v = '0;
    for (int i = 0; i < 4; i++) v[i*12 +: 12] = 12'hFFF;
    v[4*12 +: 12] = 12'hF0F;
    apply_check(4, v, "R4 odd carry AND");
    chk(res[4] == 32'h00000F0F, "R4 carried value", res[4], 32'h00000F0F);
    t_random(4, 4, "R4 odd AND random");
    t_random(5, 6, "R4 odd OR random");
  endtask

  // R10: three back-to-back vectors on the 2-stage build
  task automatic t_back_to_back();
    logic [4095:0] v0, v1, v2;
    v0 = rnd_vec(); v1 = rnd_vec(); v2 = rnd_vec();
    @(negedge clk); ops[1] = v0; vin[1] = 1'b1;
    @(negedge clk); ops[1] = v1;
    @(posedge clk); #1;
    chk(vout[1] == 1'b1, "R10 b2b first valid", 32'(vout[1]), 32'd1);
    chk(res[1] == ref_fold(1, v0), "R10 b2b first", res[1], ref_fold(1, v0));
    @(negedge clk); ops[1] = v2;
    @(posedge clk); #1;
    chk(res[1] == ref_fold(1, v1), "R10 b2b second", res[1], ref_fold(1, v1));
    @(negedge clk); vin[1] = 1'b0;
    @(posedge clk); #1;
    chk(vout[1] == 1'b1, "R10 b2b third valid", 32'(vout[1]), 32'd1);
    chk(res[1] == ref_fold(1, v2), "R10 b2b third", res[1], ref_fold(1, v2));
    @(posedge clk); #1;
    chk(vout[1] == 1'b0, "R10 b2b drained", 32'(vout[1]), 32'd0);
  endtask

  // R11: reset one cycle after acceptance on the 3-stage build
  task automatic t_reset_flush();
    bit seen;
    seen = 1'b0;
    @(negedge clk); ops[2] = rnd_vec(); vin[2] = 1'b1;
    @(negedge clk); vin[2] = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); #1;
      if (vout[2]) seen = 1'b1;
    end
    chk(!seen, "R11 flush in flight", 32'(seen), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < NCFG; k++) begin
      ops[k] = '0;
      vin[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    t_reset_state();
    t_latency(0, "R6 latency add 8");
    t_latency(6, "R6 latency add 64");
    t_latency(1, "R7 latency mul w16");
    t_latency(2, "R7 latency mul w24");
    t_latency(3, "R8 latency xor 8");
    t_latency(7, "R8 latency or 2048");
    t_latency(4, "R5 latency comb and");
    t_latency(5, "R5 latency comb or");
    t_random(0, 8, "R1 add random");
    t_random(3, 8, "R1 xor random");
    t_random(6, 4, "R1 add 64 random");
    t_random(7, 3, "R1 or 2048 random");
    t_wrap();
    t_mul_trunc();
    t_odd();
    t_back_to_back();
    t_reset_flush();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end

endmodule